// File: doc/BRIEF.md
# Broadcast Activation Launcher with Throttle

The launcher accepts activation requests from a small set of requesters. Each request carries a 6-bit descriptor-set index. From it the block forms the address of that set in memory: a programmable base plus the index times 512, because a set holds eight 64-byte descriptors. It issues this address on a fetch port. When the request carries a chaining flag, it also fetches the next descriptor of the set (base + 64) on the following cycle.

Every requester owns a 2-bit status code:

| Code | Meaning |
|------|---------|
| 0 | idle |
| 1 | active |
| 2 | destination timeout |
| 3 | source timeout |

A launch moves the requester's code from idle to active. A result event from the network side ends the activation:

- Code 0 reports a successful completion and returns the requester to idle.
- Codes 2 and 3 are timeouts. They are held until software acknowledges them.

An in-flight counter limits how many activations may be active at once. It grows only while it is strictly below a programmable limit, which defaults to 3. Software may lower the limit below the current count. New launches then wait without error until enough activations finish. A refused request raises a stall output and must be held; it is retried every cycle.

Top module: `act_launcher`

## Requirements
- R1: After reset all statuses read 0 (idle), fetch_vld_o is low, the base is 0 and the limit is 3.
- R2: An accepted launch makes fetch_vld_o high in the next cycle, with fetch_addr_o = base + index*512 and fetch_src_o = the requester. The base used is the value held before that clock edge.
- R3: A launch with act_chain_i set issues a second fetch in the following cycle at the previous address + 64. During that cycle any request stalls.
- R4: An accepted launch changes the requester's status from 0 to 1 (active) at the same edge.
- R5: A request is accepted only when the in-flight count is strictly below the limit. Otherwise act_stall_o is high, and the held request is accepted in the first cycle a slot is free.
- R6: Writing a limit below the current count (cfg_sel_i=1, value in cfg_data_i[2:0]) blocks launches without changing any status. Launching resumes once the count falls below the limit.
- R7: A result event for an active requester sets its status as follows: code 0 gives 0, code 2 gives 2, code 3 gives 3. The event lowers the in-flight count by one.
- R8: A result event for a requester that is not active, or one carrying code 1, changes no status and no count.
- R9: An acknowledge clears a status of 2 or 3 to 0. It has no effect on a status of 0 or 1.
- R10: A request from a requester whose status is not 0 stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Target of the write: 0 selects the base, 1 selects the limit |
| cfg_data_i | input | 40 | Write data. The limit uses bits [2:0] |
| act_req_i | input | 1 | Launch request, held until accepted |
| act_src_i | input | 2 | Requester number |
| act_idx_i | input | 6 | Descriptor-set index |
| act_chain_i | input | 1 | Also fetch the second descriptor |
| act_stall_o | output | 1 | Request refused this cycle |
| fetch_vld_o | output | 1 | Descriptor fetch valid |
| fetch_addr_o | output | 40 | Descriptor byte address |
| fetch_src_o | output | 2 | Requester owning the fetch |
| done_vld_i | input | 1 | Result event valid |
| done_src_i | input | 2 | Requester of the event |
| done_code_i | input | 2 | Result code: 0 completion, 2 destination timeout, 3 source timeout |
| ack_i | input | 1 | Software acknowledge |
| ack_src_i | input | 2 | Requester acknowledged |
| st_sel_i | input | 2 | Status readback select |
| st_code_o | output | 2 | Status of the selected requester |

## Verification
The hardest situation to reach from the ports is a limit lowered below an in-flight count that is already larger than it. From that state, results must trickle in one at a time before a held request may proceed. A directed sequence fills three slots, writes a limit of 1, and holds a request through two completions, checking the stall on every cycle. The sequence also checks that the third completion releases the request. Random traffic then mixes held requests, chained launches, results for idle requesters, illegal codes and occasional limit rewrites against a cycle model kept in the bench.

// File: rtl/act_launch_pkg.sv
package act_launch_pkg;
  localparam logic [1:0] ST_IDLE   = 2'd0;
  localparam logic [1:0] ST_ACTIVE = 2'd1;
  localparam logic [1:0] ST_DST_TO = 2'd2;
  localparam logic [1:0] ST_SRC_TO = 2'd3;
  localparam int SET_SHIFT  = 9;   // 8 descriptors x 64 bytes
  localparam int DESC_BYTES = 64;
endpackage

// File: rtl/act_addr_gen.sv
module act_addr_gen #(
  parameter int ADDR_W = 40,
  parameter int IDX_W  = 6,
  parameter int SRC_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_d_i,
  input  logic              launch_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              chain_i,
  output logic              fetch_vld_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [SRC_W-1:0]  fetch_src_o,
  output logic              chain_pend_o
);
  import act_launch_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] set_addr;

  assign set_addr = base_q + (ADDR_W'(idx_i) << SET_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q       <= '0;
      fetch_vld_o  <= 1'b0;
      fetch_addr_o <= '0;
      fetch_src_o  <= '0;
      chain_pend_o <= 1'b0;
    end else begin
      if (base_we_i) base_q <= base_d_i;
      chain_pend_o <= launch_i & chain_i;
      if (launch_i) begin
        fetch_vld_o  <= 1'b1;
        fetch_addr_o <= set_addr;
        fetch_src_o  <= src_i;
      end else if (chain_pend_o) begin
        fetch_vld_o  <= 1'b1;
        fetch_addr_o <= fetch_addr_o + ADDR_W'(DESC_BYTES);
      end else begin
        fetch_vld_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/act_throttle.sv
module act_throttle #(
  parameter int CNT_W     = 3,
  parameter int DEF_LIMIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim_we_i,
  input  logic [CNT_W-1:0] lim_d_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic             room_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o
);
  // strict compare: a limit under the count simply blocks
  assign room_o = cnt_o < lim_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      lim_o <= CNT_W'(DEF_LIMIT);
    end else begin
      if (lim_we_i) lim_o <= lim_d_i;
      if (inc_i && !dec_i)      cnt_o <= cnt_o + 1'b1;
      else if (dec_i && !inc_i) cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/act_status_slot.sv
module act_status_slot (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_i,
  input  logic       done_i,
  input  logic [1:0] code_i,
  input  logic       ack_i,
  output logic [1:0] st_o
);
  import act_launch_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  st_o <= ST_IDLE;
    else if (launch_i)            st_o <= ST_ACTIVE;
    else if (done_i)              st_o <= (code_i == 2'd0) ? ST_IDLE : code_i;
    else if (ack_i && st_o[1])    st_o <= ST_IDLE;
  end
endmodule

// File: rtl/act_launcher.sv
module act_launcher #(
  parameter int NUM_REQ   = 4,
  parameter int ADDR_W    = 40,
  parameter int IDX_W     = 6,
  parameter int DEF_LIMIT = 3,
  localparam int SRC_W    = $clog2(NUM_REQ),
  localparam int CNT_W    = $clog2(NUM_REQ + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              act_req_i,
  input  logic [SRC_W-1:0]  act_src_i,
  input  logic [IDX_W-1:0]  act_idx_i,
  input  logic              act_chain_i,
  output logic              act_stall_o,
  output logic              fetch_vld_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [SRC_W-1:0]  fetch_src_o,
  input  logic              done_vld_i,
  input  logic [SRC_W-1:0]  done_src_i,
  input  logic [1:0]        done_code_i,
  input  logic              ack_i,
  input  logic [SRC_W-1:0]  ack_src_i,
  input  logic [SRC_W-1:0]  st_sel_i,
  output logic [1:0]        st_code_o
);
  import act_launch_pkg::*;

  logic [NUM_REQ-1:0][1:0] st_all;
  logic [CNT_W-1:0]        cnt_q, lim_q;
  logic                    room, chain_pend, accept, done_eff;

  assign act_stall_o = act_req_i & (!room | (st_all[act_src_i] != ST_IDLE) | chain_pend);
  assign accept      = act_req_i & ~act_stall_o;
  assign done_eff    = done_vld_i & (st_all[done_src_i] == ST_ACTIVE) & (done_code_i != ST_ACTIVE);
  assign st_code_o   = st_all[st_sel_i];

  act_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SRC_W(SRC_W)) u_addr (
    .clk_i, .rst_ni,
    .base_we_i   (cfg_we_i & ~cfg_sel_i),
    .base_d_i    (cfg_data_i),
    .launch_i    (accept),
    .idx_i       (act_idx_i),
    .src_i       (act_src_i),
    .chain_i     (act_chain_i),
    .fetch_vld_o, .fetch_addr_o, .fetch_src_o,
    .chain_pend_o(chain_pend)
  );

  act_throttle #(.CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT)) u_thr (
    .clk_i, .rst_ni,
    .lim_we_i (cfg_we_i & cfg_sel_i),
    .lim_d_i  (cfg_data_i[CNT_W-1:0]),
    .inc_i    (accept),
    .dec_i    (done_eff),
    .room_o   (room),
    .cnt_o    (cnt_q),
    .lim_o    (lim_q)
  );

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
    act_status_slot u_slot (
      .clk_i, .rst_ni,
      .launch_i (accept   && act_src_i  == SRC_W'(g)),
      .done_i   (done_eff && done_src_i == SRC_W'(g)),
      .code_i   (done_code_i),
      .ack_i    (ack_i    && ack_src_i  == SRC_W'(g)),
      .st_o     (st_all[g])
    );
  end
endmodule

// File: rtl/act_launcher_chk.sv
module act_launcher_chk #(
  parameter int NUM_REQ = 4,
  parameter int SRC_W   = 2,
  parameter int CNT_W   = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    act_req_i,
  input logic                    act_stall_o,
  input logic                    fetch_vld_o,
  input logic [SRC_W-1:0]        act_src_i,
  input logic [SRC_W-1:0]        fetch_src_o,
  input logic [NUM_REQ-1:0][1:0] st_all_i,
  input logic [CNT_W-1:0]        cnt_i,
  input logic [CNT_W-1:0]        lim_i,
  input logic                    chain_pend_i
);
  logic [CNT_W-1:0] active_n;
  always_comb begin
    active_n = '0;
    for (int i = 0; i < NUM_REQ; i++)
      if (st_all_i[i] == 2'd1) active_n = active_n + 1'b1;
  end

  AST_FETCH_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_req_i && !act_stall_o |=> fetch_vld_o && fetch_src_o == $past(act_src_i)); // R2
  AST_GOES_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_req_i && !act_stall_o |=> st_all_i[fetch_src_o] == 2'd1); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i > $past(cnt_i) |-> $past(cnt_i) < $past(lim_i)); // R5
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_req_i && cnt_i >= lim_i |-> act_stall_o); // R6
  AST_CNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i == active_n); // R7
  AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_pend_i && act_req_i |-> act_stall_o); // R3
endmodule

bind act_launcher act_launcher_chk #(.NUM_REQ(NUM_REQ), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .act_req_i(act_req_i), .act_stall_o(act_stall_o),
  .fetch_vld_o(fetch_vld_o), .act_src_i(act_src_i), .fetch_src_o(fetch_src_o),
  .st_all_i(st_all), .cnt_i(cnt_q), .lim_i(lim_q), .chain_pend_i(chain_pend)
);

// File: tb/sim_act_launcher.sv
module sim_act_launcher;
  localparam int N = 4;
  localparam int AW = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [AW-1:0] cfg_data = '0;
  logic req = 0, chain = 0, dv = 0, ack = 0;
  logic [1:0] src = 0, ds = 0, dc = 0, as_ = 0, ssel = 0;
  logic [5:0] idx = 0;
  logic stall, fv;
  logic [AW-1:0] fa;
  logic [1:0] fs, stc;

  int checks = 0, errors = 0;
  logic [1:0] m_st [N];
  int m_cnt, m_lim;
  logic [AW-1:0] m_base, m_fa;
  logic m_fv, m_cp;
  logic [1:0] m_fs;

  always #4 clk = ~clk;

  act_launcher u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .act_req_i(req), .act_src_i(src), .act_idx_i(idx), .act_chain_i(chain), .act_stall_o(stall),
    .fetch_vld_o(fv), .fetch_addr_o(fa), .fetch_src_o(fs),
    .done_vld_i(dv), .done_src_i(ds), .done_code_i(dc),
    .ack_i(ack), .ack_src_i(as_), .st_sel_i(ssel), .st_code_o(stc));

  function automatic logic exp_stall();
    return req && (m_cnt >= m_lim || m_st[src] != 2'd0 || m_cp);
  endfunction

  function automatic string stall_tag();
    if (m_cp) return "R3";
    if (m_st[src] != 2'd0) return "R10";
    if (m_cnt > m_lim) return "R6";
    return "R5";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs are set at the negedge; check then advance the model one edge
  task automatic step();
    logic acc, de;
    #1;
    chk(stall_tag(), stall, exp_stall());
    chk((m_st[ssel] >= 2) ? "R7" : "R4", stc, m_st[ssel]);
    chk("R1 fetch valid", fv, m_fv);
    if (m_fv) begin
      chk(m_cp ? "R3" : "R2", fa, m_fa);
      chk("R2 src", fs, m_fs);
    end
    acc = req && !exp_stall();
    de  = dv && m_st[ds] == 2'd1 && dc != 2'd1;
    if (acc) begin m_fv = 1; m_fa = m_base + (AW'(idx) << 9); m_fs = src; end
    else if (m_cp) begin m_fv = 1; m_fa = m_fa + 64; end
    else m_fv = 0;
    m_cp = acc && chain;
    m_cnt = m_cnt + int'(acc) - int'(de);
    for (int i = 0; i < N; i++) begin
      if (acc && src == 2'(i)) m_st[i] = 2'd1;
      else if (de && ds == 2'(i)) m_st[i] = (dc == 0) ? 2'd0 : dc;
      else if (ack && as_ == 2'(i) && m_st[i][1]) m_st[i] = 2'd0;
    end
    if (cfg_we) begin
      if (cfg_sel) m_lim = int'(cfg_data[2:0]);
      else m_base = cfg_data;
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    req = 0; chain = 0; dv = 0; ack = 0; cfg_we = 0;
  endtask

  task automatic launch(input logic [1:0] s, input logic [5:0] i, input logic c);
    idle_in(); req = 1; src = s; idx = i; chain = c; ssel = s; step();
  endtask

  task automatic done(input logic [1:0] s, input logic [1:0] c);
    idle_in(); dv = 1; ds = s; dc = c; ssel = s; step();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) m_st[i] = 0;
    m_cnt = 0; m_lim = 3; m_base = '0; m_fv = 0; m_cp = 0; m_fa = '0; m_fs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, every requester idle
    for (int i = 0; i < N; i++) begin idle_in(); ssel = 2'(i); step(); end
    chk("R1 base", 64'(m_base), 64'd0);
    // R2: base write then a plain launch
    idle_in(); cfg_we = 1; cfg_sel = 0; cfg_data = 40'h12_3400_0000; step();
    launch(2'd0, 6'd5, 1'b0);
    idle_in(); step();
    // R3: chained launch, second request stalls during the second beat
    launch(2'd1, 6'd63, 1'b1);
    launch(2'd2, 6'd1, 1'b0);
    launch(2'd2, 6'd1, 1'b0);
    // R5/R1: three in flight with default limit, fourth held
    launch(2'd3, 6'd9, 1'b0);
    launch(2'd3, 6'd9, 1'b0);
    // R10: active requester asks again
    launch(2'd0, 6'd2, 1'b0);
    // R6: lower limit to 1 with three active
    idle_in(); cfg_we = 1; cfg_sel = 1; cfg_data = 40'd1; step();
    done(2'd0, 2'd0);
    launch(2'd3, 6'd9, 1'b0);
    done(2'd1, 2'd2);                 // R7 destination timeout
    launch(2'd3, 6'd9, 1'b0);         // count 1, limit 1: still held
    // R8: event on idle requester and illegal code
    done(2'd0, 2'd3);
    done(2'd2, 2'd1);
    launch(2'd3, 6'd9, 1'b0);
    done(2'd2, 2'd3);                 // R7 source timeout, frees slot
    launch(2'd3, 6'd9, 1'b0);         // R6 resumes
    // R9: ack on timeout, on active, on idle
    idle_in(); ack = 1; as_ = 2'd1; ssel = 2'd1; step();
    idle_in(); ack = 1; as_ = 2'd3; ssel = 2'd3; step();
    idle_in(); ack = 1; as_ = 2'd0; ssel = 2'd0; step();
    idle_in(); ssel = 2'd2; step();
    idle_in(); cfg_we = 1; cfg_sel = 1; cfg_data = 40'd3; step();
    // random traffic; a stalled request stays held
    for (int n = 0; n < 4000; n++) begin
      logic hold;
      hold = req && stall;
      cfg_we = 0; dv = 0; ack = 0;
      if (!hold) begin
        req = ($urandom % 2) == 0;
        src = 2'($urandom); idx = 6'($urandom); chain = ($urandom % 4) == 0;
      end
      if ($urandom % 10 < 3) begin dv = 1; ds = 2'($urandom); dc = 2'($urandom); end
      if ($urandom % 5 == 0) begin ack = 1; as_ = 2'($urandom); end
      if ($urandom % 40 == 0) begin
        cfg_we = 1; cfg_sel = $urandom % 2;
        cfg_data = cfg_sel ? AW'($urandom % 5) : {8'($urandom), 32'($urandom)};
      end
      ssel = 2'($urandom);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule